// File: doc/BRIEF.md
# Banked Video RAM Slot Scheduler

This block decides, slot by slot, which requester may use each bank of a banked video RAM. Every bank has a programmable list of eight four-bit access codes, one per timing slot. The block holds a slot index that moves forward on each slot tick from the pixel timing. Each clock it turns the code at the current slot of every bank into a one-hot grant: a pattern-name fetch for one layer, a character/bitmap fetch for one layer, a CPU access, or nothing. The grant vector of each bank also serves as its bank select.

In the normal display mode the index runs over all eight slots. In every other mode (high resolution, and the two exclusive-monitor modes) it runs over the first four slots only, so entries 4 to 7 are never served. A sequence shorter than four slots does not exist. A line-start strobe puts the index back to slot 0 at the start of each line's fetch window.

The block also checks demand. It counts the slots given to each layer within the active window of the current mode. It raises a flag for any enabled layer that has fewer slots than its format needs. Halving a layer's horizontal size doubles both its pattern-name and its character/bitmap demand. A 256-colour layer at half size therefore takes four character slots, which is a whole bank in a four-slot mode.

Top module: `vram_slot_sched`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `cur_slot` is 0. `short_flag` is 0 while reset is high, and `bank_gnt` is 0 while reset is high.
- R2: In a cycle where `slot_tick` is high and `line_start` is low, the slot index moves up by one. It does not move when `slot_tick` is low, unless R4 forces it.
- R3: In mode 0 (normal) the index runs 0,1,...,7 and then wraps from 7 to 0.
- R4: In modes 1, 2 and 3 the index runs 0..3 and wraps from 3 to 0. Slot entries 4 to 7 are never granted. If the index is above 3 when such a mode is selected, it goes to 0 on the next clock.
- R5: `line_start` sets the index to 0 on the next clock, and it takes priority over `slot_tick`.
- R6: The code for bank b, slot s is `slot_cfg[(b*8+s)*4 +: 4]`. Codes 0..NUM_LAYERS-1 grant a pattern-name fetch for layer n, which is bit n of the bank's grant field. Codes 4..4+NUM_LAYERS-1 grant a character fetch for layer n, which is bit NUM_LAYERS+n. Code 14 grants the CPU, which is bit 2*NUM_LAYERS. Bank b's field is `bank_gnt[b*(2*NUM_LAYERS+1) +: 2*NUM_LAYERS+1]`.
- R7: Every other code is idle: the bank's field is all zero. A field never has more than one bit set.
- R8: `bank_gnt` and `cur_slot` are registers and always refer to the same slot. A change of `slot_cfg` appears on `bank_gnt` one clock later.
- R9: For layer n, the demand is 1 pattern-name slot and 1 character slot (2 character slots if `layer_wide[n]`, the 256-colour format). Both numbers double when `layer_half[n]` is set. Only slots in the active window of the current mode, across all banks, are counted. `short_flag[n]` is high one clock after the inputs when either count is below its demand.
- R10: `short_flag[n]` is 0 for any layer whose `layer_en[n]` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Display mode: 0 normal, 1 high-res, 2 exclusive normal, 3 exclusive high-res |
| line_start | input | 1 | Start of a line's fetch window, resets the slot index |
| slot_tick | input | 1 | Advance to the next timing slot |
| slot_cfg | input | NUM_BANKS*32 | Four-bit access code per bank and slot |
| layer_en | input | NUM_LAYERS | Layer enabled |
| layer_wide | input | NUM_LAYERS | Layer uses the 256-colour format |
| layer_half | input | NUM_LAYERS | Layer is reduced to half width |
| cur_slot | output | 3 | Current slot index |
| bank_gnt | output | NUM_BANKS*(2*NUM_LAYERS+1) | One-hot grant per bank |
| short_flag | output | NUM_LAYERS | Layer has too few slots assigned |

## Verification
Each result is due one clock after the inputs that cause it: the slot index and every bank's grant field change together on the edge after the tick, line-start, mode or code change, and the shortage flags on the edge after a change of codes or layer settings. The bench drives inputs on the falling edge and samples on the next falling edge, exactly one rising edge later. It also samples once just after a code change and before that edge, to confirm that the old grant is still held. Sweeps cover every slot in every mode, every code value in every bank, and every combination of slot count, format, halving, mode and enable for the demand check.

// File: rtl/vsched_pkg.sv
package vsched_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] PN_BASE  = 4'h0;
  localparam logic [CODE_W-1:0] CH_BASE  = 4'h4;
  localparam logic [CODE_W-1:0] CPU_CODE = 4'hE;

  typedef enum logic [1:0] {
    MODE_NORMAL     = 2'd0,
    MODE_HIRES      = 2'd1,
    MODE_EXCL_NORM  = 2'd2,
    MODE_EXCL_HIRES = 2'd3
  } disp_mode_e;
endpackage

// File: rtl/vsched_slot_counter.sv
module vsched_slot_counter #(
  parameter int MAX_SLOTS     = 8,
  parameter int COMPACT_SLOTS = 4,
  parameter int SLOT_W        = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              compact,
  input  logic              line_start,
  input  logic              tick,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] slot_nxt
);
  logic [SLOT_W-1:0] last_slot;

  always_comb begin
    last_slot = compact ? SLOT_W'(COMPACT_SLOTS - 1) : SLOT_W'(MAX_SLOTS - 1);
    if (line_start)              slot_nxt = '0;
    else if (slot_q > last_slot) slot_nxt = '0;
    else if (tick)               slot_nxt = (slot_q == last_slot) ? '0 : slot_q + 1'b1;
    else                         slot_nxt = slot_q;
  end

  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else     slot_q <= slot_nxt;
  end

  // R5
  line_start_chk: assert property (@(posedge clk) disable iff (rst)
    $past(line_start) |-> slot_q == '0);
  // R4
  compact_range_chk: assert property (@(posedge clk) disable iff (rst)
    (compact && $past(compact)) |-> slot_q < SLOT_W'(COMPACT_SLOTS));
  // R3
  normal_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $past(tick && !line_start && !compact && slot_q == SLOT_W'(MAX_SLOTS - 1)) |-> slot_q == '0);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!tick && !line_start && !compact) |-> $stable(slot_q));
endmodule

// File: rtl/vsched_bank_decoder.sv
module vsched_bank_decoder
  import vsched_pkg::*;
#(
  parameter int MAX_SLOTS  = 8,
  parameter int NUM_LAYERS = 2,
  parameter int SLOT_W     = 3,
  parameter int GNT_W      = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [MAX_SLOTS*CODE_W-1:0] bank_cfg,
  input  logic [SLOT_W-1:0]           slot_sel,
  output logic [GNT_W-1:0]            gnt_q
);
  logic [CODE_W-1:0] code;
  logic [GNT_W-1:0]  gnt_d;

  always_comb begin
    code  = bank_cfg[slot_sel*CODE_W +: CODE_W];
    gnt_d = '0;
    for (int l = 0; l < NUM_LAYERS; l++) begin
      if (code == PN_BASE + CODE_W'(l)) gnt_d[l] = 1'b1;
      if (code == CH_BASE + CODE_W'(l)) gnt_d[NUM_LAYERS + l] = 1'b1;
    end
    if (code == CPU_CODE) gnt_d[GNT_W-1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) gnt_q <= '0;
    else     gnt_q <= gnt_d;
  end

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q));
endmodule

// File: rtl/vsched_demand_check.sv
module vsched_demand_check
  import vsched_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int MAX_SLOTS     = 8,
  parameter int COMPACT_SLOTS = 4,
  parameter int NUM_LAYERS    = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  compact,
  input  logic [NUM_BANKS*MAX_SLOTS*CODE_W-1:0] slot_cfg,
  input  logic [NUM_LAYERS-1:0]                 layer_en,
  input  logic [NUM_LAYERS-1:0]                 layer_wide,
  input  logic [NUM_LAYERS-1:0]                 layer_half,
  output logic [NUM_LAYERS-1:0]                 short_q
);
  localparam int CNT_W = $clog2(NUM_BANKS * MAX_SLOTS + 1) + 1;

  logic [CNT_W-1:0]      pn_cnt  [NUM_LAYERS];
  logic [CNT_W-1:0]      ch_cnt  [NUM_LAYERS];
  logic [CNT_W-1:0]      need_pn [NUM_LAYERS];
  logic [CNT_W-1:0]      need_ch [NUM_LAYERS];
  logic [NUM_LAYERS-1:0] short_d;
  logic [CODE_W-1:0]     code;
  int                    active;

  always_comb begin
    active = compact ? COMPACT_SLOTS : MAX_SLOTS;
    code   = '0;
    for (int l = 0; l < NUM_LAYERS; l++) begin
      pn_cnt[l] = '0;
      ch_cnt[l] = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        for (int s = 0; s < MAX_SLOTS; s++) begin
          code = slot_cfg[(b*MAX_SLOTS + s)*CODE_W +: CODE_W];
          if (s < active && code == PN_BASE + CODE_W'(l)) pn_cnt[l] = pn_cnt[l] + 1'b1;
          if (s < active && code == CH_BASE + CODE_W'(l)) ch_cnt[l] = ch_cnt[l] + 1'b1;
        end
      end
      need_pn[l] = CNT_W'(1) << layer_half[l];
      need_ch[l] = (layer_wide[l] ? CNT_W'(2) : CNT_W'(1)) << layer_half[l];
      short_d[l] = layer_en[l] && ((pn_cnt[l] < need_pn[l]) || (ch_cnt[l] < need_ch[l]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) short_q <= '0;
    else     short_q <= short_d;
  end

  for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_chk
    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!layer_en[g]) |-> !short_q[g]);
  end
endmodule

// File: rtl/vram_slot_sched.sv
module vram_slot_sched
  import vsched_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int NUM_LAYERS    = 2,
  parameter int MAX_SLOTS     = 8,
  parameter int COMPACT_SLOTS = 4
) (
  input  logic                                           clk,
  input  logic                                           rst,
  input  logic [1:0]                                     mode,
  input  logic                                           line_start,
  input  logic                                           slot_tick,
  input  logic [NUM_BANKS*MAX_SLOTS*4-1:0]               slot_cfg,
  input  logic [NUM_LAYERS-1:0]                          layer_en,
  input  logic [NUM_LAYERS-1:0]                          layer_wide,
  input  logic [NUM_LAYERS-1:0]                          layer_half,
  output logic [$clog2(MAX_SLOTS)-1:0]                   cur_slot,
  output logic [NUM_BANKS*(2*NUM_LAYERS+1)-1:0]          bank_gnt,
  output logic [NUM_LAYERS-1:0]                          short_flag
);
  localparam int SLOT_W = $clog2(MAX_SLOTS);
  localparam int GNT_W  = 2 * NUM_LAYERS + 1;
  localparam int BANK_W = MAX_SLOTS * CODE_W;

  logic              compact;
  logic [SLOT_W-1:0] slot_nxt;

  assign compact = (disp_mode_e'(mode) != MODE_NORMAL);

  vsched_slot_counter #(
    .MAX_SLOTS(MAX_SLOTS), .COMPACT_SLOTS(COMPACT_SLOTS), .SLOT_W(SLOT_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .compact(compact), .line_start(line_start),
    .tick(slot_tick), .slot_q(cur_slot), .slot_nxt(slot_nxt)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    vsched_bank_decoder #(
      .MAX_SLOTS(MAX_SLOTS), .NUM_LAYERS(NUM_LAYERS), .SLOT_W(SLOT_W), .GNT_W(GNT_W)
    ) u_dec (
      .clk(clk), .rst(rst),
      .bank_cfg(slot_cfg[b*BANK_W +: BANK_W]),
      .slot_sel(slot_nxt),
      .gnt_q(bank_gnt[b*GNT_W +: GNT_W])
    );
  end

  vsched_demand_check #(
    .NUM_BANKS(NUM_BANKS), .MAX_SLOTS(MAX_SLOTS),
    .COMPACT_SLOTS(COMPACT_SLOTS), .NUM_LAYERS(NUM_LAYERS)
  ) u_dem (
    .clk(clk), .rst(rst), .compact(compact), .slot_cfg(slot_cfg),
    .layer_en(layer_en), .layer_wide(layer_wide), .layer_half(layer_half),
    .short_q(short_flag)
  );

  // R4
  upper_unused_chk: assert property (@(posedge clk) disable iff (rst)
    (compact && $past(compact)) |-> cur_slot < SLOT_W'(COMPACT_SLOTS));
endmodule

// File: tb/vram_slot_sched_tb.sv
module vram_slot_sched_tb;
  localparam int NB = 4, NL = 2, MS = 8, GW = 2*NL+1;

  logic clk = 0, rst = 1, line_start = 0, slot_tick = 0;
  logic [1:0] mode = 0;
  logic [NB*MS*4-1:0] slot_cfg = '0;
  logic [NL-1:0] layer_en = 0, layer_wide = 0, layer_half = 0;
  logic [2:0] cur_slot;
  logic [NB*GW-1:0] bank_gnt;
  logic [NL-1:0] short_flag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vram_slot_sched u_dut (.clk(clk), .rst(rst), .mode(mode), .line_start(line_start),
    .slot_tick(slot_tick), .slot_cfg(slot_cfg), .layer_en(layer_en),
    .layer_wide(layer_wide), .layer_half(layer_half), .cur_slot(cur_slot),
    .bank_gnt(bank_gnt), .short_flag(short_flag));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_gnt(int code);
    if (code < NL) return 1 << code;
    if (code >= 4 && code < 4 + NL) return 1 << (NL + code - 4);
    if (code == 14) return 1 << (2*NL);
    return 0;
  endfunction

  function automatic int exp_all(int s);
    int v = 0;
    for (int b = 0; b < NB; b++) v |= exp_gnt(int'(slot_cfg[(b*MS+s)*4 +: 4])) << (b*GW);
    return v;
  endfunction

  task automatic cyc(logic tk, logic ls);
    slot_tick = tk; line_start = ls;
    @(negedge clk);
    slot_tick = 0; line_start = 0;
  endtask

  task automatic set_code(int b, int s, int c);
    slot_cfg[(b*MS+s)*4 +: 4] = 4'(c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int b = 0; b < NB; b++) for (int s = 0; s < MS; s++) set_code(b, s, 14);
    layer_en = 2'b11;
    repeat (3) @(negedge clk);
    chk("R1 slot in reset", int'(cur_slot), 0);
    chk("R1 grant in reset", int'(bank_gnt), 0);
    chk("R1 flag in reset", int'(short_flag), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 slot after reset", int'(cur_slot), 0);

    // R3 R6 R7: sweep all codes in normal mode
    for (int seed = 0; seed < 4; seed++) begin
      for (int b = 0; b < NB; b++) for (int s = 0; s < MS; s++) set_code(b, s, (b*3 + s*5 + seed*7) % 16);
      cyc(0, 1);
      for (int i = 0; i < 17; i++) begin
        chk("R3 slot walk", int'(cur_slot), i % 8);
        chk("R6 R7 grant map", int'(bank_gnt), exp_all(i % 8));
        cyc(1, 0);
      end
    end

    // R2 hold without tick
    cyc(0, 1); cyc(1, 0); cyc(1, 0);
    cyc(0, 0); cyc(0, 0);
    chk("R2 hold", int'(cur_slot), 2);

    // R4 compact modes, upper entries CPU
    for (int m = 1; m < 4; m++) begin
      mode = 2'(m);
      for (int b = 0; b < NB; b++) for (int s = 0; s < MS; s++) set_code(b, s, s < 4 ? (b + s) % 8 : 14);
      cyc(0, 1);
      for (int i = 0; i < 13; i++) begin
        chk("R4 compact walk", int'(cur_slot), i % 4);
        chk("R4 upper ignored", int'(bank_gnt), exp_all(i % 4));
        cyc(1, 0);
      end
    end

    // R4 mode switch with index above 3
    mode = 0;
    cyc(0, 1);
    for (int i = 0; i < 6; i++) cyc(1, 0);
    chk("R3 reached 6", int'(cur_slot), 6);
    mode = 1;
    cyc(0, 0);
    chk("R4 switch to compact", int'(cur_slot), 0);
    mode = 0;

    // R5 line_start beats tick
    cyc(1, 0); cyc(1, 0);
    cyc(1, 1);
    chk("R5 line start priority", int'(cur_slot), 0);

    // R8 grant latency on code change
    for (int b = 0; b < NB; b++) for (int s = 0; s < MS; s++) set_code(b, s, 15);
    cyc(0, 0);
    chk("R8 idle before", int'(bank_gnt), 0);
    set_code(2, 0, 14);
    #1;
    chk("R8 old grant held", int'(bank_gnt), 0);
    @(negedge clk);
    chk("R8 new grant one clock later", int'(bank_gnt), exp_all(0));

    // R9 R10 demand sweep
    for (int md = 0; md < 2; md++)
      for (int k = 0; k < 9; k++)
        for (int w = 0; w < 2; w++)
          for (int h = 0; h < 2; h++)
            for (int e1 = 0; e1 < 2; e1++) begin
              int nact, chc, f0;
              mode = md ? 2'd3 : 2'd0;
              for (int b = 0; b < NB; b++) for (int s = 0; s < MS; s++) set_code(b, s, 15);
              for (int s = 0; s < k; s++) set_code(0, s, 4);
              set_code(1, 0, 0); set_code(1, 1, 0);
              layer_en = {1'(e1), 1'b1};
              layer_wide = {1'b0, 1'(w)};
              layer_half = {1'b0, 1'(h)};
              @(negedge clk);
              nact = md ? 4 : 8;
              chc = (k < nact) ? k : nact;
              f0 = (chc < ((w ? 2 : 1) << h)) || (2 < (1 << h)) ? 1 : 0;
              chk("R9 layer0 shortfall", int'(short_flag[0]), f0);
              chk("R10 layer1 enable gating", int'(short_flag[1]), e1);
            end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule